// File: doc/BRIEF.md
# Keyed Watchdog Timer

This peripheral supervises software by counting upward on a slow functional clock and raising a reset pulse when the count wraps past its all-ones value. Software talks to it over a simple register bus clocked by a faster interface clock. It sets the reload value and the prescaler, and it refreshes the timer by writing the trigger register, which copies the load value back into the counter. The counter can be started or halted only by writing an ordered pair of key words to the key register. A single stray write therefore cannot enable or disable supervision.

Every write to the control, load, trigger or key register is posted. The bus side accepts it at once and carries it into the functional clock domain through a toggle handshake. A per-register pending flag in the status register stays high until the acknowledge has returned, so software can wait for each write to land before issuing the next one. The running count is passed back to the bus domain through a second handshake, so a read of the counter register always returns a coherent snapshot.

Top module: `wdt_keyed_top`

## Requirements
- R1: Key writes of 0xBBBB and then 0x4444, in that order, start the counter. Only the low 16 bits of a key write are compared.
- R2: Key writes of 0xAAAA and then 0x5555, in that order, halt the counter.
- R3: A key write that is not the expected next value of a sequence returns the key logic to its idle step and leaves the run state unchanged.
- R4: The status register (address 0x04) has these pending flags: bit 0 for control (0x08), bit 2 for load (0x10), bit 3 for trigger (0x14) and bit 4 for key (0x18). A flag reads 1 on the first read after its register is written and returns to 0 once the write has reached the functional domain. All other status bits read 0.
- R5: A write to a register whose pending flag is still set is dropped, and reading that register returns the earlier value.
- R6: A trigger write reloads the counter from the load register, whether the counter is running or halted. While the counter is halted and no trigger arrives, the counter holds its value. The counter register (0x0C) returns the count.
- R7: Control bit 5 enables the prescaler and bits 4:2 hold a value P. With the prescaler enabled, the counter advances once every 2^P functional ticks. With it disabled, the counter advances on every tick.
- R8: When the counter steps past all ones, `wdt_rst_o` goes high for exactly one functional cycle and the counter reloads from the load register. With load value L, successive pulses are therefore (2^32 − L)·2^P functional cycles apart when the prescaler is enabled, or (2^32 − L) cycles apart when it is disabled.
- R9: The revision register (0x00) returns REV_CODE (default 0x41) in bits 7:0 and zero above.
- R10: After reset the counter is halted, and control, load, counter and status all read 0.
- R11: Read data appears on `bus_rdata` in the bus cycle after the one in which `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| clk_fn | input | 1 | Slow functional clock that drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | One-cycle reset pulse on counter wrap, in the functional domain |

## Verification
The hardest condition to reach from the ports is a precise wrap period under every prescale setting. The counter is free-running in the slow domain, while every control change arrives late and at a phase the bus cannot see. The bench loads a value a few counts below the wrap point and changes the prescale value while the counter runs. It discards the first pulses after each change and then measures the exact spacing between later pulses, which no longer depends on when the change landed. Dropped writes and mismatched key sequences are reached by writing again before a pending flag clears and by interleaving wrong key words. Their effect is then read back through the load and counter registers or seen in the pulse count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 5;
  localparam int unsigned NUM_CH = 4;

  localparam logic [BUS_AW-1:0] A_REV   = 5'h00;
  localparam logic [BUS_AW-1:0] A_STAT  = 5'h04;
  localparam logic [BUS_AW-1:0] A_CTRL  = 5'h08;
  localparam logic [BUS_AW-1:0] A_COUNT = 5'h0C;
  localparam logic [BUS_AW-1:0] A_LOAD  = 5'h10;
  localparam logic [BUS_AW-1:0] A_TRIG  = 5'h14;
  localparam logic [BUS_AW-1:0] A_KEY   = 5'h18;

  localparam int unsigned CH_CTRL = 0;
  localparam int unsigned CH_LOAD = 1;
  localparam int unsigned CH_TRIG = 2;
  localparam int unsigned CH_KEY  = 3;

  localparam logic [BUS_DW-1:0] CTRL_MASK = 32'h0000_003C;

  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;
  localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_B = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ARM_RUN,
    KS_ARM_HALT
  } key_step_e;

  function automatic logic [BUS_AW-1:0] ch_addr(input int unsigned ch);
    case (ch)
      CH_CTRL: ch_addr = A_CTRL;
      CH_LOAD: ch_addr = A_LOAD;
      CH_TRIG: ch_addr = A_TRIG;
      default: ch_addr = A_KEY;
    endcase
  endfunction

endpackage

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_src,
  input  logic          rst_src_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] hold_o,
  output logic          pend_o,
  input  logic          clk_dst,
  input  logic          rst_dst_n,
  output logic [DW-1:0] data_o,
  output logic          stb_o
);

  // source side
  logic          req_q, req_n;
  logic [DW-1:0] hold_q, hold_n;
  logic          ack_s1_q, ack_s2_q;
  logic          accept;

  assign pend_o = req_q ^ ack_s2_q;
  assign accept = wr_i & ~pend_o;

  always_comb begin
    req_n  = req_q;
    hold_n = hold_q;
    if (accept) begin
      req_n  = ~req_q;
      hold_n = wdata_i;
    end
  end

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) begin
      req_q    <= 1'b0;
      hold_q   <= '0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      req_q    <= req_n;
      hold_q   <= hold_n;
      ack_s1_q <= ack_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  assign hold_o = hold_q;

  // destination side
  logic          req_s1_q, req_s2_q;
  logic          ack_q, ack_n;
  logic [DW-1:0] data_q, data_n;
  logic          stb_q, stb_n;
  logic          land;

  assign land = req_s2_q ^ ack_q;

  always_comb begin
    ack_n  = ack_q;
    data_n = data_q;
    stb_n  = 1'b0;
    if (land) begin
      ack_n  = req_s2_q;
      data_n = hold_q;
      stb_n  = 1'b1;
    end
  end

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      ack_q    <= 1'b0;
      data_q   <= '0;
      stb_q    <= 1'b0;
    end else begin
      req_s1_q <= req_q;
      req_s2_q <= req_s1_q;
      ack_q    <= ack_n;
      data_q   <= data_n;
      stb_q    <= stb_n;
    end
  end

  assign data_o = data_q;
  assign stb_o  = stb_q;

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_stb_i,
  input  logic [15:0] key_i,
  output logic        run_o
);

  key_step_e step_q, step_n;
  logic      run_q, run_n;

  always_comb begin
    step_n = step_q;
    run_n  = run_q;
    if (key_stb_i) begin
      step_n = KS_IDLE;
      case (step_q)
        KS_IDLE: begin
          if (key_i == KEY_RUN_A)       step_n = KS_ARM_RUN;
          else if (key_i == KEY_HALT_A) step_n = KS_ARM_HALT;
        end
        KS_ARM_RUN:  if (key_i == KEY_RUN_B)  run_n = 1'b1;
        KS_ARM_HALT: if (key_i == KEY_HALT_B) run_n = 1'b0;
        default: step_n = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= KS_IDLE;
      run_q  <= 1'b0;
    end else begin
      step_q <= step_n;
      run_q  <= run_n;
    end
  end

  assign run_o = run_q;

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] ptv_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] pre_q, pre_n;
  logic             wrap_q, wrap_n;
  logic [DIV_W-1:0] pre_lim;
  logic             tick;

  assign pre_lim = DIV_W'((32'd1 << ptv_i) - 32'd1);
  assign tick    = ~pre_en_i | (pre_q >= pre_lim);

  always_comb begin
    cnt_n  = cnt_q;
    pre_n  = pre_q;
    wrap_n = 1'b0;
    if (reload_i) begin
      cnt_n = load_i;
      pre_n = '0;
    end else if (run_i) begin
      if (tick) begin
        pre_n = '0;
        if (&cnt_q) begin
          cnt_n  = load_i;
          wrap_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pre_q  <= pre_n;
      wrap_q <= wrap_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

endmodule

// File: rtl/wdt_cnt_mirror.sv
module wdt_cnt_mirror #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_src,
  input  logic          rst_src_n,
  input  logic [DW-1:0] val_i,
  input  logic          clk_dst,
  input  logic          rst_dst_n,
  output logic [DW-1:0] val_o
);

  // source: refresh the snapshot whenever the previous one was taken
  logic          sreq_q, sreq_n;
  logic [DW-1:0] snap_q, snap_n;
  logic          ack_s1_q, ack_s2_q;

  always_comb begin
    sreq_n = sreq_q;
    snap_n = snap_q;
    if (ack_s2_q == sreq_q) begin
      sreq_n = ~sreq_q;
      snap_n = val_i;
    end
  end

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) begin
      sreq_q   <= 1'b0;
      snap_q   <= '0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      sreq_q   <= sreq_n;
      snap_q   <= snap_n;
      ack_s1_q <= dack_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  // destination: capture once per toggle
  logic          req_s1_q, req_s2_q;
  logic          dack_q, dack_n;
  logic [DW-1:0] mir_q, mir_n;

  always_comb begin
    dack_n = dack_q;
    mir_n  = mir_q;
    if (req_s2_q != dack_q) begin
      dack_n = req_s2_q;
      mir_n  = snap_q;
    end
  end

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      dack_q   <= 1'b0;
      mir_q    <= '0;
    end else begin
      req_s1_q <= sreq_q;
      req_s2_q <= req_s1_q;
      dack_q   <= dack_n;
      mir_q    <= mir_n;
    end
  end

  assign val_o = mir_q;

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PRE_W    = 3,
  parameter logic [7:0]  REV_CODE = 8'h41
) (
  input  logic              clk_bus,
  input  logic              clk_fn,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              wdt_rst_o
);

  localparam int unsigned PTV_LSB = 2;
  localparam int unsigned PEN_BIT = PTV_LSB + PRE_W;

  // reset release per domain
  logic [1:0] rst_bus_sq, rst_fn_sq;
  logic       rst_bus_n, rst_fn_n;

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) rst_bus_sq <= 2'b00;
    else        rst_bus_sq <= {rst_bus_sq[0], 1'b1};
  end

  always_ff @(posedge clk_fn or negedge rst_n) begin
    if (!rst_n) rst_fn_sq <= 2'b00;
    else        rst_fn_sq <= {rst_fn_sq[0], 1'b1};
  end

  assign rst_bus_n = rst_bus_sq[1];
  assign rst_fn_n  = rst_fn_sq[1];

  // posted write channels
  logic [NUM_CH-1:0][BUS_DW-1:0] hold;
  logic [NUM_CH-1:0][BUS_DW-1:0] dat;
  logic [NUM_CH-1:0]             pend;
  logic [NUM_CH-1:0]             stb;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && (bus_addr == ch_addr(i));
    wdt_post_chan #(.DW(BUS_DW)) u_chan (
      .clk_src   (clk_bus),
      .rst_src_n (rst_bus_n),
      .wr_i      (ch_wr),
      .wdata_i   (bus_wdata),
      .hold_o    (hold[i]),
      .pend_o    (pend[i]),
      .clk_dst   (clk_fn),
      .rst_dst_n (rst_fn_n),
      .data_o    (dat[i]),
      .stb_o     (stb[i])
    );
  end

  // functional domain
  logic             run;
  logic             key_stb;
  logic [15:0]      key_val;
  logic [CNT_W-1:0] load_val;
  logic             reload_stb;
  logic [CNT_W-1:0] cnt;
  logic             pre_en;
  logic [PRE_W-1:0] ptv;

  assign key_stb    = stb[CH_KEY];
  assign key_val    = dat[CH_KEY][15:0];
  assign load_val   = dat[CH_LOAD][CNT_W-1:0];
  assign reload_stb = stb[CH_TRIG];
  assign pre_en     = dat[CH_CTRL][PEN_BIT];
  assign ptv        = dat[CH_CTRL][PTV_LSB +: PRE_W];

  wdt_key_seq u_key (
    .clk       (clk_fn),
    .rst_n     (rst_fn_n),
    .key_stb_i (key_stb),
    .key_i     (key_val),
    .run_o     (run)
  );

  wdt_count_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk      (clk_fn),
    .rst_n    (rst_fn_n),
    .run_i    (run),
    .pre_en_i (pre_en),
    .ptv_i    (ptv),
    .load_i   (load_val),
    .reload_i (reload_stb),
    .cnt_o    (cnt),
    .wrap_o   (wdt_rst_o)
  );

  logic [CNT_W-1:0] cnt_mir;

  wdt_cnt_mirror #(.DW(CNT_W)) u_mirror (
    .clk_src   (clk_fn),
    .rst_src_n (rst_fn_n),
    .val_i     (cnt),
    .clk_dst   (clk_bus),
    .rst_dst_n (rst_bus_n),
    .val_o     (cnt_mir)
  );

  // register read path
  logic [BUS_DW-1:0] status;
  logic [BUS_DW-1:0] rd_mux;
  logic [BUS_DW-1:0] rdata_q, rdata_n;

  assign status = {27'b0, pend[CH_KEY], pend[CH_TRIG], pend[CH_LOAD], 1'b0, pend[CH_CTRL]};

  always_comb begin
    case (bus_addr)
      A_REV:   rd_mux = {24'b0, REV_CODE};
      A_STAT:  rd_mux = status;
      A_CTRL:  rd_mux = hold[CH_CTRL] & CTRL_MASK;
      A_COUNT: rd_mux = BUS_DW'(cnt_mir);
      A_LOAD:  rd_mux = hold[CH_LOAD];
      A_TRIG:  rd_mux = hold[CH_TRIG];
      A_KEY:   rd_mux = hold[CH_KEY];
      default: rd_mux = '0;
    endcase
    rdata_n = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) rdata_q <= '0;
    else            rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk_fn,
  input logic                          rst_fn_n,
  input logic                          clk_bus,
  input logic                          rst_bus_n,
  input logic                          run,
  input logic                          key_stb,
  input logic [15:0]                   key_val,
  input logic [CNT_W-1:0]              cnt,
  input logic [CNT_W-1:0]              load_val,
  input logic                          reload_stb,
  input logic                          wdt_rst_o,
  input logic                          bus_wr,
  input logic [BUS_AW-1:0]             bus_addr,
  input logic [NUM_CH-1:0]             pend,
  input logic [NUM_CH-1:0][BUS_DW-1:0] hold
);

  // R8
  pulse_width_chk: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
    wdt_rst_o |=> !wdt_rst_o);

  // R8
  wrap_reload_chk: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
    wdt_rst_o |-> (cnt == $past(load_val)));

  // R1
  start_key_chk: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
    $rose(run) |-> $past(key_stb && (key_val == KEY_RUN_B)));

  // R2
  stop_key_chk: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
    $fell(run) |-> $past(key_stb && (key_val == KEY_HALT_B)));

  // R6
  halted_hold_chk: assert property (@(posedge clk_fn) disable iff (!rst_fn_n)
    (!run && !reload_stb) |=> $stable(cnt));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_drop
    // R5
    drop_busy_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (bus_wr && (bus_addr == ch_addr(i)) && pend[i]) |=> $stable(hold[i]));
  end

endmodule

bind wdt_keyed_top wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_fn     (clk_fn),
  .rst_fn_n   (rst_fn_n),
  .clk_bus    (clk_bus),
  .rst_bus_n  (rst_bus_n),
  .run        (run),
  .key_stb    (key_stb),
  .key_val    (key_val),
  .cnt        (cnt),
  .load_val   (load_val),
  .reload_stb (reload_stb),
  .wdt_rst_o  (wdt_rst_o),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .pend       (pend),
  .hold       (hold)
);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;

  logic        clk_bus = 1'b0;
  logic        clk_fn  = 1'b0;
  logic        rst_n;
  logic        bus_rd, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4  clk_bus = ~clk_bus;
  always #28 clk_fn  = ~clk_fn;

  wdt_keyed_top dut (
    .clk_bus   (clk_bus),
    .clk_fn    (clk_fn),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_rst_o (wdt_rst_o)
  );

  // pulse monitor, sampled between functional edges
  int fn_cyc    = 0;
  int pulses    = 0;
  int t_last    = 0;
  int t_prev    = 0;
  int width_bad = 0;
  bit prev_hi   = 1'b0;

  always @(negedge clk_fn) begin
    fn_cyc <= fn_cyc + 1;
    if (wdt_rst_o) begin
      pulses <= pulses + 1;
      t_prev <= t_last;
      t_last <= fn_cyc;
      if (prev_hi) width_bad <= width_bad + 1;
    end
    prev_hi <= wdt_rst_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk_bus);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    s = 32'hFFFF_FFFF;
    for (int k = 0; k < 100 && s != 0; k++) bus_read(5'h04, s);
    chk(req, s, 32'h0);
  endtask

  task automatic post(input logic [4:0] a, input logic [31:0] d);
    bus_write(a, d);
    wait_idle("R4 flags clear");
  endtask

  task automatic fn_wait(input int n);
    repeat (n) @(negedge clk_fn);
  endtask

  task automatic meas_gap(input string req, input int exp);
    int n0;
    n0 = pulses;
    for (int k = 0; k < 3000 && pulses < n0 + 3; k++) @(negedge clk_fn);
    chk(req, t_last - t_prev, exp);
  endtask

  initial begin
    int c;
    c = 0;
    while (!done) begin
      @(posedge clk_bus);
      c++;
      if (c > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r, r2;
    int n0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    fn_wait(3);
    @(negedge clk_bus) rst_n = 1'b1;
    fn_wait(4);

    // R9 R10 R11: reset state and revision
    bus_read(5'h00, r); chk("R9 revision", r, 32'h41);
    bus_read(5'h04, r); chk("R10 status", r, 32'h0);
    bus_read(5'h08, r); chk("R10 control", r, 32'h0);
    bus_read(5'h10, r); chk("R10 load", r, 32'h0);
    bus_read(5'h0C, r); chk("R10 counter", r, 32'h0);
    chk("R10 no pulse", pulses, 0);

    // R4: each pending flag in its own bit
    bus_write(5'h08, 32'h0);        bus_read(5'h04, r); chk("R4 ctrl bit0", r, 32'h01); wait_idle("R4 ctrl");
    bus_write(5'h10, 32'h1234);     bus_read(5'h04, r); chk("R4 load bit2", r, 32'h04); wait_idle("R4 load");
    bus_write(5'h14, 32'h0);        bus_read(5'h04, r); chk("R4 trig bit3", r, 32'h08); wait_idle("R4 trig");
    bus_write(5'h18, 32'h0);        bus_read(5'h04, r); chk("R4 key bit4", r, 32'h10);  wait_idle("R4 key");

    // R6: trigger reloads while halted, value held
    fn_wait(30);
    bus_read(5'h0C, r); chk("R6 reload halted", r, 32'h1234);
    fn_wait(40);
    bus_read(5'h0C, r); chk("R6 halted holds", r, 32'h1234);

    // R5: second write during pending is dropped
    bus_write(5'h10, 32'hFFFF_FFFE);
    bus_write(5'h10, 32'h0000_0055);
    wait_idle("R5 idle");
    bus_read(5'h10, r); chk("R5 load kept", r, 32'hFFFF_FFFE);
    post(5'h14, 32'h0);
    fn_wait(30);
    bus_read(5'h0C, r); chk("R6 reload value", r, 32'hFFFF_FFFE);

    // R3: wrong key orders do not start the counter
    post(5'h18, 32'h4444);
    post(5'h18, 32'hBBBB);
    post(5'h18, 32'h1234);
    post(5'h18, 32'h4444);
    post(5'h18, 32'hBBBB);
    post(5'h18, 32'hAAAA);
    post(5'h18, 32'h4444);
    fn_wait(60);
    chk("R3 no start pulses", pulses, 0);
    bus_read(5'h0C, r); chk("R3 counter held", r, 32'hFFFF_FFFE);

    // R1: proper start sequence, upper key bits ignored
    post(5'h18, 32'h0001_BBBB);
    post(5'h18, 32'h4444);
    meas_gap("R1 R8 running gap", 2);

    // R7: prescale sweep with load two below wrap
    for (int p = 0; p < 8; p++) begin
      post(5'h08, 32'h20 | (p << 2));
      meas_gap($sformatf("R7 prescale p=%0d", p), 2 << p);
    end
    post(5'h08, 32'h1C);
    meas_gap("R7 prescaler disabled", 2);

    // R8: load sweep
    post(5'h10, 32'hFFFF_FFF0); meas_gap("R8 gap 16", 16);
    post(5'h10, 32'hFFFF_FFFB); meas_gap("R8 gap 5", 5);
    post(5'h10, 32'hFFFF_FF80); meas_gap("R8 gap 128", 128);
    chk("R8 single-cycle pulses", width_bad, 0);

    // R6: repeated trigger keeps the counter from wrapping
    post(5'h10, 32'hFFFF_FF00);
    post(5'h14, 32'h0);
    fn_wait(4);
    n0 = pulses;
    for (int k = 0; k < 40; k++) begin
      post(5'h14, 32'h0);
      fn_wait(20);
    end
    chk("R6 trigger refresh", pulses, n0);

    // R3: broken stop sequence leaves it running
    post(5'h18, 32'hAAAA);
    post(5'h18, 32'h0000);
    post(5'h18, 32'h5555);
    meas_gap("R3 still running", 256);

    // R2: stop
    post(5'h18, 32'hAAAA);
    post(5'h18, 32'h5555);
    fn_wait(5);
    n0 = pulses;
    fn_wait(600);
    chk("R2 no pulses halted", pulses, n0);
    bus_read(5'h0C, r);
    fn_wait(50);
    bus_read(5'h0C, r2);
    chk("R2 counter frozen", r2, r);
    post(5'h14, 32'h0);
    fn_wait(30);
    bus_read(5'h0C, r); chk("R6 reload after stop", r, 32'hFFFF_FF00);
    chk("R8 single-cycle pulses final", width_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule